// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM. Address and command are captured on one clock edge, and the data for that command moves in the following cycle. Reads and writes share this timing, so a read can follow a write, or a write a read, with no idle cycle on the data bus. The bus master never has to steer the output enable itself. Read data is flow-through: during the data cycle it comes straight from the array, with no output register.

The bidirectional data bus appears as three ports: `din`, `dout` and a drive-enable `dout_en`. Three chip selects together gate the start of a new access. A load/advance input either loads a fresh address or steps a 4-beat burst, in linear or interleaved order. Per-lane active-low write strobes limit a write to some byte lanes. A clock-enable input freezes the whole block. The output-enable input and the sleep input force the bus to high impedance.

Top module: `zt_sram`

## Requirements
- R1: After a synchronous reset, `dout_en` is 0 and no access is pending.
- R2: A read command (`adv`=0, `rw`=1, all chip selects active) sampled on an edge makes the next cycle a read data cycle. In that cycle `dout_en`=1 and `dout` holds the word at the sampled address.
- R3: A write command (`rw`=0) sampled on an edge makes the next cycle a write data cycle. `din` is stored on the edge that ends that cycle. Lane i is `din[i*LANE_W +: LANE_W]`, and it changes only when `lane_we_n[i]`, sampled with the command, is 0.
- R4: Commands may alternate between write and read on consecutive edges with no idle cycle. A read issued directly after a write to the same address returns the new data.
- R5: A load (`adv`=0) with any chip select inactive (`sel1_n`=1, `sel2`=0 or `sel3_n`=1) starts no access, and `dout_en` is 0 in the following cycle. A transfer already pending still completes.
- R6: With `adv`=1 after an accepted load, each edge steps the burst counter k=1,2,3,0,… and keeps the loaded read/write type. The upper address bits stay fixed. The low two bits are (a+k) mod 4 when `burst_lin` was 1 at the load, and a XOR k when it was 0.
- R7: On an edge with `cke_n`=1, all synchronous inputs are ignored and all state holds. A pending read keeps driving its word. A pending write is stored on the first later edge with `cke_n`=0, using `din` at that edge.
- R8: `oe_n`=1 forces `dout_en` to 0 at once, without waiting for a clock edge.
- R9: While `sleep`=1, `dout_en` is 0 at once and edges start no access. Array contents are kept, and normal work resumes once `sleep` returns to 0.
- R10: `dout_en` is 0 during a write data cycle.
- R11: `adv`=1 when no burst is active (after reset or after a deselect) starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Clock enable, active low |
| rw | input | 1 | 1 = read, 0 = write (sampled on a load) |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 = load new address, 1 = advance burst |
| burst_lin | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| lane_we_n | input | LANES | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep: blocks new accesses, floats the bus |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Flow-through read data |
| dout_en | output | 1 | Bus drive enable |

## Verification
The hardest situation to reach is a write held in flight. Its command has been accepted, but clock enable goes high before the data edge. The block must then keep the address and lane mask, and store only the `din` present at the later enabled edge. The bench issues a write, raises `cke_n` while presenting decoy data for one edge, then lowers it with the real data. It reads the word back and expects the real data only. Bursts are checked by writing in linear order and reading in interleaved order from an unaligned start, so the returned sequence depends on both orders and on wrap-around.

// File: rtl/zt_pkg.sv
package zt_pkg;
  localparam int BURST_LEN = 4;
  localparam int BURST_W   = $clog2(BURST_LEN);

  // Low address bits of burst beat cnt from base, linear or interleaved.
  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] base,
    input logic [BURST_W-1:0] cnt,
    input logic               lin
  );
    return lin ? (base + cnt) : (base ^ cnt);
  endfunction
endpackage

// File: rtl/zt_cmd.sv
module zt_cmd
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_n,
  input  logic              sleep,
  input  logic              rw,
  input  logic              ce_all,
  input  logic              adv,
  input  logic              burst_lin,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we_n,
  output logic              op_valid,
  output logic              op_rd,
  output logic [ADDR_W-1:0] op_addr,
  output logic [LANES-1:0]  op_we_n
);
  logic              valid_q, rd_q, lin_q, burst_on_q;
  logic [ADDR_W-1:0] base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [LANES-1:0]  we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= 1'b0;
      burst_on_q <= 1'b0;
      rd_q       <= 1'b1;
      lin_q      <= 1'b1;
      base_q     <= '0;
      cnt_q      <= '0;
      we_q       <= '1;
    end else if (!cke_n) begin
      if (sleep) begin
        valid_q    <= 1'b0;
        burst_on_q <= 1'b0;
      end else if (!adv) begin
        if (ce_all) begin
          valid_q    <= 1'b1;
          burst_on_q <= 1'b1;
          rd_q       <= rw;
          lin_q      <= burst_lin;
          base_q     <= addr;
          cnt_q      <= '0;
          we_q       <= lane_we_n;
        end else begin
          valid_q    <= 1'b0;
          burst_on_q <= 1'b0;
        end
      end else if (burst_on_q) begin
        valid_q <= 1'b1;
        cnt_q   <= cnt_q + 1'b1;
        we_q    <= lane_we_n;
      end else begin
        valid_q <= 1'b0;
      end
    end
  end

  assign op_valid = valid_q;
  assign op_rd    = rd_q;
  assign op_we_n  = we_q;
  assign op_addr  = {base_q[ADDR_W-1:BURST_W], burst_low(base_q[BURST_W-1:0], cnt_q, lin_q)};

  // R7: a disabled clock edge changes nothing
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    cke_n |=> ($stable(op_addr) && $stable(op_valid) && $stable(op_rd) && $stable(op_we_n)));

  // R5: load with a chip select inactive starts nothing
  p_desel_r5: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !sleep && !adv && !ce_all) |=> !op_valid);

  // R2: accepted load presents the sampled address
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !sleep && !adv && ce_all) |=> (op_valid && op_addr == $past(addr)));

  // R6: an advance keeps the upper address bits and the access type
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !sleep && adv && burst_on_q) |=>
      (op_valid && $stable(op_rd) && $stable(op_addr[ADDR_W-1:BURST_W])));

  // R11: advance with no burst active starts nothing
  p_noburst_r11: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && adv && !burst_on_q) |=> !op_valid);
endmodule

// File: rtl/zt_array.sv
module zt_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr,
  input  logic [LANES-1:0]        lane_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr && lane_en[g])
        mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[addr];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_n,
  input  logic              rw,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              adv,
  input  logic              burst_lin,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     dout,
  output logic              dout_en
);
  logic              ce_all;
  logic              op_valid, op_rd;
  logic [ADDR_W-1:0] op_addr;
  logic [LANES-1:0]  op_we_n;
  logic              wr_now;

  assign ce_all = !sel1_n && sel2 && !sel3_n;

  zt_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst(rst), .cke_n(cke_n), .sleep(sleep), .rw(rw),
    .ce_all(ce_all), .adv(adv), .burst_lin(burst_lin), .addr(addr),
    .lane_we_n(lane_we_n), .op_valid(op_valid), .op_rd(op_rd),
    .op_addr(op_addr), .op_we_n(op_we_n)
  );

  assign wr_now = op_valid && !op_rd && !cke_n;

  zt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wr(wr_now), .lane_en(~op_we_n), .addr(op_addr),
    .wdata(din), .rdata(dout)
  );

  assign dout_en = op_valid && op_rd && !oe_n && !sleep;

  // R8: output enable high floats the bus
  p_oe_off_r8: assert property (@(posedge clk) disable iff (rst) oe_n |-> !dout_en);

  // R9: sleep floats the bus
  p_sleep_off_r9: assert property (@(posedge clk) disable iff (rst) sleep |-> !dout_en);

  // R10: no drive in a write data cycle
  p_wr_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_rd) |-> !dout_en);

  // R1: right after reset nothing drives
  p_rst_quiet_r1: assert property (@(posedge clk) $past(rst) |-> !dout_en);
endmodule

// File: tb/tb_zt_sram.sv
module tb_zt_sram;
  localparam int AW = 8, LN = 2, LW = 9, DW = LN * LW;

  logic clk = 1'b0, rst = 1'b1;
  logic cke_n = 1'b0, rw = 1'b1, sel1_n = 1'b1, sel2 = 1'b1, sel3_n = 1'b0;
  logic adv = 1'b0, burst_lin = 1'b1, oe_n = 1'b0, sleep = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LN-1:0] lane_we_n = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (.*);

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sel_ok();
    sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
  endtask
  task automatic cmd_rd(logic [AW-1:0] a, logic lin = 1'b1);
    sel_ok(); adv = 1'b0; rw = 1'b1; addr = a; burst_lin = lin;
  endtask
  task automatic cmd_wr(logic [AW-1:0] a, logic [LN-1:0] we, logic lin = 1'b1);
    sel_ok(); adv = 1'b0; rw = 1'b0; addr = a; lane_we_n = we; burst_lin = lin;
  endtask
  task automatic cmd_nop();
    sel1_n = 1'b1; adv = 1'b0; rw = 1'b1; addr = 8'hFF;
  endtask
  task automatic cmd_adv(logic [LN-1:0] we = '0);
    adv = 1'b1; lane_we_n = we; rw = ~rw;
  endtask
  task automatic step(); @(negedge clk); endtask

  task automatic t_reset();
    rst = 1'b1; cmd_nop();
    repeat (3) step();
    rst = 1'b0;
    step();
    chk("R1 no drive after reset", dout_en, 1'b0);
  endtask

  task automatic t_basic();
    cmd_wr(8'h10, 2'b00); step();
    din = 18'h2A5A5; cmd_rd(8'h10);
    chk("R10 no drive in write cycle", dout_en, 1'b0); step();
    chk("R2 read enable", dout_en, 1'b1);
    chk("R2 read data", dout, 18'h2A5A5);
    cmd_nop(); step();
    chk("R5 float after deselect", dout_en, 1'b0);
    cmd_wr(8'h10, 2'b10); step();
    din = 18'h0F0F3; cmd_rd(8'h10); step();
    chk("R3 lane mask write", dout, {9'h152, 9'h0F3});
    cmd_nop(); step();
  endtask

  task automatic t_turnaround();
    cmd_wr(8'h20, 2'b00); step();
    din = 18'h11111; cmd_rd(8'h20); step();
    chk("R4 read after write en", dout_en, 1'b1);
    chk("R4 read after write data", dout, 18'h11111);
    cmd_wr(8'h21, 2'b00); step();
    chk("R4 write cycle float", dout_en, 1'b0);
    din = 18'h22222; cmd_rd(8'h21); step();
    chk("R4 second read data", dout, 18'h22222);
    cmd_nop(); step();
  endtask

  task automatic t_burst();
    logic [DW-1:0] w [4];
    for (int k = 0; k < 4; k++) w[k] = DW'(18'h30000 + k * 18'h01111);
    cmd_wr(8'h31, 2'b00, 1'b1); step();
    for (int k = 0; k < 4; k++) begin
      din = w[k];
      if (k < 3) cmd_adv(2'b00); else cmd_nop();
      step();
    end
    // linear from 0x31: 31,32,33,30 hold w0..w3; interleaved read 31,30,33,32
    cmd_rd(8'h31, 1'b0); step();
    chk("R6 interleaved beat0", dout, w[0]); cmd_adv(); step();
    chk("R6 interleaved beat1", dout, w[3]); cmd_adv(); step();
    chk("R6 interleaved beat2", dout, w[2]); cmd_adv(); step();
    chk("R6 interleaved beat3", dout, w[1]);
    chk("R6 burst keeps read type", dout_en, 1'b1);
    cmd_nop(); step();
    cmd_rd(8'h32, 1'b1); step();
    chk("R6 linear beat0", dout, w[1]); cmd_adv(); step();
    chk("R6 linear beat1", dout, w[2]); cmd_adv(); step();
    chk("R6 linear wrap", dout, w[3]);
    cmd_nop(); step();
  endtask

  task automatic t_deselect();
    for (int i = 0; i < 3; i++) begin
      cmd_rd(8'h10);
      if (i == 0) sel1_n = 1'b1; else if (i == 1) sel2 = 1'b0; else sel3_n = 1'b1;
      step();
      chk("R5 chip select blocks access", dout_en, 1'b0);
    end
    cmd_rd(8'h20); step();
    cmd_rd(8'h21); sel2 = 1'b0;
    chk("R5 pending read completes", dout, 18'h11111); step();
    chk("R5 float after deselect", dout_en, 1'b0);
    cmd_adv(); rw = 1'b1; step();
    chk("R11 advance without burst", dout_en, 1'b0);
    cmd_nop(); step();
  endtask

  task automatic t_clock_enable();
    cmd_rd(8'h20); step();
    cke_n = 1'b1; cmd_wr(8'h21, 2'b00); step();
    chk("R7 held read enable", dout_en, 1'b1);
    chk("R7 held read data", dout, 18'h11111);
    cmd_nop(); step();
    chk("R7 still held", dout, 18'h11111);
    cke_n = 1'b0; step();
    chk("R7 resumes after enable", dout_en, 1'b0);
    cmd_wr(8'h40, 2'b00); step();
    cke_n = 1'b1; din = 18'h3DEAD; cmd_nop(); step();
    cke_n = 1'b0; din = 18'h0BEEF; step();
    din = 18'h1FFFF; cmd_rd(8'h40); step();
    chk("R7 suspended write uses late data", dout, 18'h0BEEF);
    cmd_rd(8'h21); step();
    chk("R7 ignored command left word", dout, 18'h22222);
    cmd_nop(); step();
  endtask

  task automatic t_oe_sleep();
    cmd_rd(8'h10); step();
    oe_n = 1'b1; #1;
    chk("R8 async float", dout_en, 1'b0);
    oe_n = 1'b0; #1;
    chk("R8 async drive back", dout_en, 1'b1);
    sleep = 1'b1; #1;
    chk("R9 sleep floats", dout_en, 1'b0);
    cmd_wr(8'h10, 2'b00); din = 18'h00000; step();
    din = 18'h00001; step();
    sleep = 1'b0; cmd_nop(); step();
    chk("R9 no access after sleep", dout_en, 1'b0);
    cmd_rd(8'h10); step();
    chk("R9 contents kept", dout, {9'h152, 9'h0F3});
    cmd_nop(); step();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_turnaround();
    t_burst();
    t_deselect();
    t_clock_enable();
    t_oe_sleep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule